// File: doc/BRIEF.md
# Display Identification Block Timing Extractor

This block takes in the 128-byte base block of a monitor's identification data, one byte for each accepted beat, and turns it into one set of parallel video-mode fields. While the bytes stream past, it compares the eight-byte signature at the start of the block and keeps a running mod-256 sum. From the four 18-byte descriptor slots it keeps the first one that actually carries a timing. When the last byte arrives it reports a status code and the decoded mode together.

The decoded mode gives the pixel clock in 10 kHz units, the horizontal and vertical active and blanking sizes, the sync offsets, the sync pulse widths and the two sync polarities. Each 12-bit, 10-bit and 6-bit field is put back together from a low byte (or nibble) and from high bits that several fields share in one packed byte. A start pulse re-arms the parser so that a later block can be read.

Top module: `disp_id_timing_parser`

## Requirements
- R1: Bytes 0 to 7 must read 00, FF, FF, FF, FF, FF, FF, 00. Any mismatch gives status 1 (bad signature). This status wins over every other status.
- R2: If the 8-bit sum of all 128 bytes is not zero and the signature is good, the status is 2 (bad sum).
- R3: The descriptor slots start at byte offsets 54, 72, 90 and 108. A slot is empty only when its first two bytes are both zero. The fields come from the lowest-numbered slot that is not empty, and later slots are ignored.
- R4: If all four slots are empty, and the signature and the sum are good, the status is 3 (no timing). A status of 0 means the block is good.
- R5: The pixel clock output is slot byte 1 (upper half) joined to slot byte 0 (lower half).
- R6: Horizontal active is {byte4[7:4], byte2}. Horizontal blanking is {byte4[3:0], byte3}. Vertical active is {byte7[7:4], byte5}. Vertical blanking is {byte7[3:0], byte6}.
- R7: Horizontal sync offset is {byte11[7:6], byte8}. Horizontal sync width is {byte11[5:4], byte9}. Vertical sync offset is {byte11[3:2], byte10[7:4]}. Vertical sync width is {byte11[1:0], byte10[3:0]}.
- R8: When slot byte 17 bits 4:3 equal 2'b11, vsync_pos equals bit 2 and hsync_pos equals bit 1, where 1 means positive. For any other value of bits 4:3, both outputs are 0.
- R9: done is high for exactly one cycle, in the cycle after the beat that carries byte 127. Gaps in in_valid are allowed. The status and field outputs change only in that cycle.
- R10: After byte 127, further beats are ignored until start is pulsed. They produce no done and leave the outputs unchanged.
- R11: start clears the byte position, the sum, the signature flag and the slot selection, and re-arms the parser. A beat in the same cycle as start is dropped.
- R12: After reset, done, the status and all fields are zero. When done reports a nonzero status, all fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Re-arm for a new block; a beat in the same cycle is dropped |
| in_valid | input | 1 | in_byte carries the next block byte |
| in_byte | input | 8 | Block byte |
| done | output | 1 | One-cycle pulse when the result is ready |
| err_code | output | 2 | 0 good, 1 bad signature, 2 bad sum, 3 no timing |
| pix_clk_10k | output | 16 | Pixel clock in 10 kHz units |
| h_active | output | 12 | Horizontal active pixels |
| h_blank | output | 12 | Horizontal blanking pixels |
| v_active | output | 12 | Vertical active lines |
| v_blank | output | 12 | Vertical blanking lines |
| h_sync_off | output | 10 | Horizontal sync offset |
| h_sync_wid | output | 10 | Horizontal sync pulse width |
| v_sync_off | output | 6 | Vertical sync offset |
| v_sync_wid | output | 6 | Vertical sync pulse width |
| vsync_pos | output | 1 | Vertical sync is positive |
| hsync_pos | output | 1 | Horizontal sync is positive |

## Verification
A re-arm pulse can arrive in the same cycle as an accepted beat. The hardest case is when that beat is the final checksum byte, because the completion and the restart then compete for the same edge. The bench sends a pulse together with byte 127 and expects no done and unchanged outputs, then sends a whole block straight away and expects a good result. It also sends a pulse together with a junk byte and follows it directly with a clean block. The clean block must decode correctly, which shows that the junk byte never took the position of byte 0.

// File: rtl/disp_id_pkg.sv
package disp_id_pkg;

  localparam int SIG_BYTES = 8;

  typedef enum logic [1:0] {
    ST_GOOD      = 2'd0,
    ST_BAD_SIG   = 2'd1,
    ST_BAD_SUM   = 2'd2,
    ST_NO_TIMING = 2'd3
  } parse_status_e;

  typedef struct packed {
    logic [15:0] pclk;
    logic [11:0] h_act;
    logic [11:0] h_blk;
    logic [11:0] v_act;
    logic [11:0] v_blk;
    logic [9:0]  h_off;
    logic [9:0]  h_wid;
    logic [5:0]  v_off;
    logic [5:0]  v_wid;
    logic        vs_pos;
    logic        hs_pos;
  } video_mode_t;

  // expected signature byte at a position inside the first SIG_BYTES bytes
  function automatic logic [7:0] sig_byte(input int unsigned pos);
    return (pos == 0 || pos == SIG_BYTES - 1) ? 8'h00 : 8'hFF;
  endfunction

  // 12-bit size whose high nibble sits in the upper half of a packed byte
  function automatic logic [11:0] join_upper_nib(input logic [7:0] pk, input logic [7:0] lo);
    return {pk[7:4], lo};
  endfunction

  // 12-bit size whose high nibble sits in the lower half of a packed byte
  function automatic logic [11:0] join_lower_nib(input logic [7:0] pk, input logic [7:0] lo);
    return {pk[3:0], lo};
  endfunction

  function automatic logic [9:0] join_ten(input logic [1:0] hi, input logic [7:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [5:0] join_six(input logic [1:0] hi, input logic [3:0] lo);
    return {hi, lo};
  endfunction

  // returns {vsync positive, hsync positive}
  function automatic logic [1:0] sync_polarity(input logic [7:0] flags);
    return (flags[4:3] == 2'b11) ? {flags[2], flags[1]} : 2'b00;
  endfunction

endpackage

// File: rtl/disp_id_byte_tracker.sv
module disp_id_byte_tracker
  import disp_id_pkg::*;
#(
  parameter int BLOCK_LEN = 128
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         in_valid,
  input  logic [7:0]                   in_byte,
  output logic [$clog2(BLOCK_LEN)-1:0] idx,
  output logic                         beat_accept,
  output logic                         last_beat,
  output logic [7:0]                   sum_final,
  output logic                         sig_bad_final
);
  localparam int IDX_W = $clog2(BLOCK_LEN);

  logic       armed;
  logic [7:0] sum_q;
  logic       sig_bad_q;
  logic       sig_miss;

  assign beat_accept   = in_valid && armed && !start;
  assign last_beat     = beat_accept && (idx == IDX_W'(BLOCK_LEN - 1));
  assign sum_final     = sum_q + in_byte;
  assign sig_miss      = beat_accept && (idx < IDX_W'(SIG_BYTES)) &&
                         (in_byte != sig_byte(int'(idx)));
  assign sig_bad_final = sig_bad_q || sig_miss;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b1;
      idx       <= '0;
      sum_q     <= '0;
      sig_bad_q <= 1'b0;
    end else if (start) begin
      armed     <= 1'b1;
      idx       <= '0;
      sum_q     <= '0;
      sig_bad_q <= 1'b0;
    end else if (beat_accept) begin
      sum_q     <= sum_final;
      sig_bad_q <= sig_bad_final;
      if (last_beat) begin
        armed <= 1'b0;
        idx   <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/disp_id_desc_capture.sv
module disp_id_desc_capture #(
  parameter int BLOCK_LEN  = 128,
  parameter int DESC_BASE  = 54,
  parameter int DESC_LEN   = 18,
  parameter int DESC_COUNT = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear,
  input  logic                         beat_accept,
  input  logic [$clog2(BLOCK_LEN)-1:0] idx,
  input  logic [7:0]                   in_byte,
  output logic [DESC_LEN*8-1:0]        desc_flat,
  output logic                         locked
);
  localparam int IDX_W    = $clog2(BLOCK_LEN);
  localparam int DESC_END = DESC_BASE + DESC_LEN * DESC_COUNT;

  logic [7:0]       stage [DESC_LEN];
  logic [IDX_W-1:0] rel;
  logic [IDX_W-1:0] offs;
  logic             in_desc;
  logic             cap;
  logic             slot_end;

  assign rel      = idx - IDX_W'(DESC_BASE);
  assign offs     = rel % IDX_W'(DESC_LEN);
  assign in_desc  = (idx >= IDX_W'(DESC_BASE)) && (idx < IDX_W'(DESC_END));
  assign cap      = beat_accept && !locked && in_desc;
  assign slot_end = cap && (offs == IDX_W'(DESC_LEN - 1));

  for (genvar g = 0; g < DESC_LEN; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          stage[g] <= '0;
      else if (clear)                      stage[g] <= '0;
      else if (cap && offs == IDX_W'(g))   stage[g] <= in_byte;
    end
    assign desc_flat[g*8 +: 8] = stage[g];
  end

  // a slot is taken once its last byte is in and its first two are not both zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                          locked <= 1'b0;
    else if (clear)                                      locked <= 1'b0;
    else if (slot_end && ((stage[0] | stage[1]) != 8'h00)) locked <= 1'b1;
  end

endmodule

// File: rtl/disp_id_field_build.sv
module disp_id_field_build
  import disp_id_pkg::*;
#(
  parameter int DESC_LEN = 18
) (
  input  logic [DESC_LEN*8-1:0] desc_flat,
  output video_mode_t           mode
);
  logic [7:0] db [DESC_LEN];
  logic [1:0] pol;
  logic       unused_filler;

  for (genvar g = 0; g < DESC_LEN; g++) begin : g_bytes
    assign db[g] = desc_flat[g*8 +: 8];
  end

  assign pol           = sync_polarity(db[17]);
  assign unused_filler = ^{db[12], db[13], db[14], db[15], db[16]};

  always_comb begin
    mode        = '0;
    mode.pclk   = {db[1], db[0]};
    mode.h_act  = join_upper_nib(db[4], db[2]);
    mode.h_blk  = join_lower_nib(db[4], db[3]);
    mode.v_act  = join_upper_nib(db[7], db[5]);
    mode.v_blk  = join_lower_nib(db[7], db[6]);
    mode.h_off  = join_ten(db[11][7:6], db[8]);
    mode.h_wid  = join_ten(db[11][5:4], db[9]);
    mode.v_off  = join_six(db[11][3:2], db[10][7:4]);
    mode.v_wid  = join_six(db[11][1:0], db[10][3:0]);
    mode.vs_pos = pol[1];
    mode.hs_pos = pol[0];
  end

endmodule

// File: rtl/disp_id_timing_parser.sv
module disp_id_timing_parser
  import disp_id_pkg::*;
#(
  parameter int BLOCK_LEN  = 128,
  parameter int DESC_BASE  = 54,
  parameter int DESC_LEN   = 18,
  parameter int DESC_COUNT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  output logic        done,
  output logic [1:0]  err_code,
  output logic [15:0] pix_clk_10k,
  output logic [11:0] h_active,
  output logic [11:0] h_blank,
  output logic [11:0] v_active,
  output logic [11:0] v_blank,
  output logic [9:0]  h_sync_off,
  output logic [9:0]  h_sync_wid,
  output logic [5:0]  v_sync_off,
  output logic [5:0]  v_sync_wid,
  output logic        vsync_pos,
  output logic        hsync_pos
);
  localparam int IDX_W = $clog2(BLOCK_LEN);

  logic [IDX_W-1:0]      idx;
  logic                  beat_accept;
  logic                  last_beat;
  logic [7:0]            sum_final;
  logic                  sig_bad_final;
  logic [DESC_LEN*8-1:0] desc_flat;
  logic                  locked;
  video_mode_t           built;
  video_mode_t           mode_q;
  parse_status_e         status_now;
  parse_status_e         status_q;
  logic                  done_q;

  disp_id_byte_tracker #(.BLOCK_LEN(BLOCK_LEN)) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .in_valid     (in_valid),
    .in_byte      (in_byte),
    .idx          (idx),
    .beat_accept  (beat_accept),
    .last_beat    (last_beat),
    .sum_final    (sum_final),
    .sig_bad_final(sig_bad_final)
  );

  disp_id_desc_capture #(
    .BLOCK_LEN (BLOCK_LEN),
    .DESC_BASE (DESC_BASE),
    .DESC_LEN  (DESC_LEN),
    .DESC_COUNT(DESC_COUNT)
  ) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start),
    .beat_accept(beat_accept),
    .idx        (idx),
    .in_byte    (in_byte),
    .desc_flat  (desc_flat),
    .locked     (locked)
  );

  disp_id_field_build #(.DESC_LEN(DESC_LEN)) u_build (
    .desc_flat(desc_flat),
    .mode     (built)
  );

  // priority: signature, then sum, then presence of a timing
  always_comb begin
    if (sig_bad_final)          status_now = ST_BAD_SIG;
    else if (sum_final != 8'h00) status_now = ST_BAD_SUM;
    else if (!locked)           status_now = ST_NO_TIMING;
    else                        status_now = ST_GOOD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      status_q <= ST_GOOD;
      mode_q   <= '0;
    end else begin
      done_q <= last_beat;
      if (last_beat) begin
        status_q <= status_now;
        mode_q   <= (status_now == ST_GOOD) ? built : '0;
      end
    end
  end

  assign done        = done_q;
  assign err_code    = status_q;
  assign pix_clk_10k = mode_q.pclk;
  assign h_active    = mode_q.h_act;
  assign h_blank     = mode_q.h_blk;
  assign v_active    = mode_q.v_act;
  assign v_blank     = mode_q.v_blk;
  assign h_sync_off  = mode_q.h_off;
  assign h_sync_wid  = mode_q.h_wid;
  assign v_sync_off  = mode_q.v_off;
  assign v_sync_wid  = mode_q.v_wid;
  assign vsync_pos   = mode_q.vs_pos;
  assign hsync_pos   = mode_q.hs_pos;

endmodule

// File: rtl/disp_id_timing_checker.sv
module disp_id_timing_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        beat_accept,
  input logic        last_beat,
  input logic        done,
  input logic [1:0]  err_code,
  input logic [97:0] mode_bits
);

  // R9
  done_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> done);

  // R9
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(err_code) && $stable(mode_bits)));

  // R10
  idle_after_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !beat_accept);

  // R11
  start_blocks_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);

  // R12
  error_clears_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code != 2'd0) |-> (mode_bits == '0));

endmodule

bind disp_id_timing_parser disp_id_timing_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .beat_accept(beat_accept),
  .last_beat  (last_beat),
  .done       (done),
  .err_code   (err_code),
  .mode_bits  (mode_q)
);

// File: tb/disp_id_timing_parser_bench.sv
module disp_id_timing_parser_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        done;
  logic [1:0]  err_code;
  logic [15:0] pix_clk_10k;
  logic [11:0] h_active, h_blank, v_active, v_blank;
  logic [9:0]  h_sync_off, h_sync_wid;
  logic [5:0]  v_sync_off, v_sync_wid;
  logic        vsync_pos, hsync_pos;

  int total = 0;
  int fails = 0;
  logic [7:0]  blk [128];
  logic [31:0] seed = 32'h1234_5678;

  logic [1:0]  e_err;
  logic [15:0] e_pc;
  logic [11:0] e_ha, e_hb, e_va, e_vb;
  logic [9:0]  e_ho, e_hw;
  logic [5:0]  e_vo, e_vw;
  logic        e_vp, e_hp;

  logic [99:0] act_vec;
  logic [99:0] exp_vec;
  assign act_vec = {err_code, pix_clk_10k, h_active, h_blank, v_active, v_blank,
                    h_sync_off, h_sync_wid, v_sync_off, v_sync_wid, vsync_pos, hsync_pos};
  assign exp_vec = {e_err, e_pc, e_ha, e_hb, e_va, e_vb, e_ho, e_hw, e_vo, e_vw, e_vp, e_hp};

  always #10 clk = ~clk;

  disp_id_timing_parser u_disp_id_timing_parser (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_byte(in_byte),
    .done(done), .err_code(err_code), .pix_clk_10k(pix_clk_10k),
    .h_active(h_active), .h_blank(h_blank), .v_active(v_active), .v_blank(v_blank),
    .h_sync_off(h_sync_off), .h_sync_wid(h_sync_wid),
    .v_sync_off(v_sync_off), .v_sync_wid(v_sync_wid),
    .vsync_pos(vsync_pos), .hsync_pos(hsync_pos)
  );

  task automatic chk(input string tag, input logic [99:0] act, input logic [99:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rnd(output logic [31:0] r);
    seed = seed * 32'd1103515245 + 32'd12345;
    r = seed;
  endtask

  task automatic base_block();
    for (int i = 0; i < 8; i++) blk[i] = (i == 0 || i == 7) ? 8'h00 : 8'hFF;
    for (int i = 8; i < 54; i++) blk[i] = 8'(i * 13 + 1);
    for (int s = 0; s < 4; s++) begin
      blk[54 + 18*s]     = 8'h00;
      blk[54 + 18*s + 1] = 8'h00;
      for (int k = 2; k < 18; k++) blk[54 + 18*s + k] = 8'(8'h3C + k);
    end
    blk[126] = 8'h00;
    blk[127] = 8'h00;
  endtask

  task automatic fix_sum();
    logic [7:0] s;
    s = 8'h00;
    for (int i = 0; i < 127; i++) s = s + blk[i];
    blk[127] = 8'h00 - s;
  endtask

  task automatic put_desc(input int slot, input logic [15:0] pc,
                          input logic [11:0] ha, input logic [11:0] hb,
                          input logic [11:0] va, input logic [11:0] vb,
                          input logic [9:0] ho, input logic [9:0] hw,
                          input logic [5:0] vo, input logic [5:0] vw,
                          input logic [7:0] fl);
    int b;
    b = 54 + 18*slot;
    blk[b]    = pc[7:0];
    blk[b+1]  = pc[15:8];
    blk[b+2]  = ha[7:0];
    blk[b+3]  = hb[7:0];
    blk[b+4]  = {ha[11:8], hb[11:8]};
    blk[b+5]  = va[7:0];
    blk[b+6]  = vb[7:0];
    blk[b+7]  = {va[11:8], vb[11:8]};
    blk[b+8]  = ho[7:0];
    blk[b+9]  = hw[7:0];
    blk[b+10] = {vo[3:0], vw[3:0]};
    blk[b+11] = {ho[9:8], hw[9:8], vo[5:4], vw[5:4]};
    for (int k = 12; k < 17; k++) blk[b+k] = 8'(8'hA5 ^ k);
    blk[b+17] = fl;
  endtask

  task automatic expect_good(input logic [15:0] pc,
                             input logic [11:0] ha, input logic [11:0] hb,
                             input logic [11:0] va, input logic [11:0] vb,
                             input logic [9:0] ho, input logic [9:0] hw,
                             input logic [5:0] vo, input logic [5:0] vw,
                             input logic [7:0] fl);
    e_err = 2'd0; e_pc = pc; e_ha = ha; e_hb = hb; e_va = va; e_vb = vb;
    e_ho = ho; e_hw = hw; e_vo = vo; e_vw = vw;
    e_vp = (fl[4] && fl[3]) ? fl[2] : 1'b0;
    e_hp = (fl[4] && fl[3]) ? fl[1] : 1'b0;
  endtask

  task automatic expect_err(input logic [1:0] code);
    e_err = code; e_pc = '0; e_ha = '0; e_hb = '0; e_va = '0; e_vb = '0;
    e_ho = '0; e_hw = '0; e_vo = '0; e_vw = '0; e_vp = 1'b0; e_hp = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic stream(input int first, input int last, input bit gaps);
    for (int i = first; i <= last; i++) begin
      if (gaps && (i % 5 == 2)) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = blk[i];
    end
  endtask

  task automatic finish_check(input string tag);
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " done"}, 100'(done), 100'd1);
    chk(tag, act_vec, exp_vec);
    @(negedge clk);
    chk({tag, " pulse"}, 100'(done), 100'd0);
  endtask

  task automatic run_block(input string tag, input bit gaps);
    pulse_start();
    stream(0, 127, gaps);
    finish_check(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL R9 watchdog act=no_end exp=end");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] r1, r2, r3, r4;
    logic [99:0] held;
    int slot;
    logic [15:0] pc;
    logic [7:0]  fl;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    expect_err(2'd0);
    chk("R12 reset done", 100'(done), 100'd0);
    chk("R12 reset outputs", act_vec, exp_vec);

    // R5 R6 R7 R8 basic good block in slot 0
    base_block();
    put_desc(0, 16'h1A2B, 12'h780, 12'h118, 12'h438, 12'h02D, 10'h058, 10'h02C, 6'h04, 6'h05, 8'h1E);
    fix_sum();
    expect_good(16'h1A2B, 12'h780, 12'h118, 12'h438, 12'h02D, 10'h058, 10'h02C, 6'h04, 6'h05, 8'h1E);
    run_block("R5 R6 R7 R8 basic", 1'b0);

    // R10 extra beats after byte 127 are ignored
    held = act_vec;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_byte = 8'h55;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R10 no done after end", 100'(done), 100'd0);
    end
    chk("R10 outputs unchanged", act_vec, held);

    // R3 first nonempty slot wins; empty slots carry junk past byte 1
    base_block();
    put_desc(2, 16'h2233, 12'h123, 12'h456, 12'h789, 12'hABC, 10'h3FF, 10'h155, 6'h3F, 6'h2A, 8'h18);
    put_desc(3, 16'h9999, 12'hFFF, 12'hFFF, 12'hFFF, 12'hFFF, 10'h000, 10'h000, 6'h00, 6'h00, 8'h1E);
    fix_sum();
    expect_good(16'h2233, 12'h123, 12'h456, 12'h789, 12'hABC, 10'h3FF, 10'h155, 6'h3F, 6'h2A, 8'h18);
    run_block("R3 slot2 chosen", 1'b1);

    // R3 R5 slot with byte0 zero but byte1 nonzero is not empty
    base_block();
    put_desc(0, 16'h0700, 12'h001, 12'h002, 12'h003, 12'h004, 10'h005, 10'h006, 6'h07, 6'h08, 8'h00);
    put_desc(1, 16'h4444, 12'h111, 12'h111, 12'h111, 12'h111, 10'h111, 10'h111, 6'h11, 6'h11, 8'h1E);
    fix_sum();
    expect_good(16'h0700, 12'h001, 12'h002, 12'h003, 12'h004, 10'h005, 10'h006, 6'h07, 6'h08, 8'h00);
    run_block("R3 R5 high byte only", 1'b0);

    // R4 all slots empty
    base_block();
    fix_sum();
    expect_err(2'd3);
    run_block("R4 no timing", 1'b0);

    // R2 bad sum, header fine, timing present
    base_block();
    put_desc(1, 16'h1111, 12'h222, 12'h333, 12'h444, 12'h555, 10'h066, 10'h077, 6'h08, 6'h09, 8'h1E);
    fix_sum();
    blk[127] = blk[127] ^ 8'h01;
    expect_err(2'd2);
    run_block("R2 R12 bad sum", 1'b0);

    // R1 bad signature wins over bad sum
    base_block();
    put_desc(0, 16'h1111, 12'h222, 12'h333, 12'h444, 12'h555, 10'h066, 10'h077, 6'h08, 6'h09, 8'h1E);
    blk[3] = 8'hFE;
    expect_err(2'd1);
    run_block("R1 bad sig and sum", 1'b0);

    // R1 bad signature at byte 0 with sum repaired
    base_block();
    put_desc(0, 16'h1111, 12'h222, 12'h333, 12'h444, 12'h555, 10'h066, 10'h077, 6'h08, 6'h09, 8'h1E);
    blk[0] = 8'h01;
    fix_sum();
    expect_err(2'd1);
    run_block("R1 bad sig byte0", 1'b0);

    // R1 bad signature at byte 7, no timing
    base_block();
    blk[7] = 8'h80;
    fix_sum();
    expect_err(2'd1);
    run_block("R1 bad sig byte7", 1'b0);

    // R8 sweep over sync kind and polarity bits
    for (int k = 0; k < 16; k++) begin
      fl = {3'b101, 4'(k), 1'b1};
      base_block();
      put_desc(k % 4, 16'h0101, 12'h010, 12'h020, 12'h030, 12'h040, 10'h050, 10'h060, 6'h07, 6'h08, fl);
      fix_sum();
      expect_good(16'h0101, 12'h010, 12'h020, 12'h030, 12'h040, 10'h050, 10'h060, 6'h07, 6'h08, fl);
      run_block("R8 polarity sweep", 1'b0);
    end

    // R3 R5 R6 R7 R9 pseudo-random fields, slots and gaps
    for (int n = 0; n < 40; n++) begin
      rnd(r1); rnd(r2); rnd(r3); rnd(r4);
      slot = n % 4;
      pc = r1[15:0];
      if (n % 5 == 0) pc = {r1[15:8] | 8'h01, 8'h00};
      else if (pc == 16'h0000) pc = 16'h0001;
      base_block();
      put_desc(slot, pc, r1[27:16], r2[11:0], r2[23:12], r3[11:0],
               r3[21:12], r4[9:0], r4[15:10], r4[21:16], r4[31:24]);
      if (slot < 3)
        put_desc(slot + 1, 16'hBEEF, r2[11:0], r1[27:16], r3[11:0], r2[23:12],
                 r4[9:0], r3[21:12], r4[21:16], r4[15:10], 8'h1E);
      fix_sum();
      expect_good(pc, r1[27:16], r2[11:0], r2[23:12], r3[11:0],
                  r3[21:12], r4[9:0], r4[15:10], r4[21:16], r4[31:24]);
      run_block("R3 R5 R6 R7 R9 sweep", (n % 3) == 0);
    end

    // R11 start mid-stream, then a clean block
    base_block();
    put_desc(0, 16'h0F0F, 12'h00A, 12'h00B, 12'h00C, 12'h00D, 10'h00E, 10'h00F, 6'h10, 6'h11, 8'h18);
    blk[1] = 8'hEE;
    pulse_start();
    stream(0, 49, 1'b0);
    blk[1] = 8'hFF;
    fix_sum();
    expect_good(16'h0F0F, 12'h00A, 12'h00B, 12'h00C, 12'h00D, 10'h00E, 10'h00F, 6'h10, 6'h11, 8'h18);
    run_block("R11 restart mid block", 1'b0);

    // R11 start together with byte 127: no done, outputs held
    held = act_vec;
    pulse_start();
    stream(0, 126, 1'b0);
    @(negedge clk);
    start = 1'b1; in_valid = 1'b1; in_byte = blk[127];
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0;
    chk("R11 start beats last byte", 100'(done), 100'd0);
    @(negedge clk);
    chk("R11 still no done", 100'(done), 100'd0);
    chk("R11 outputs held", act_vec, held);
    run_block("R11 block after collision", 1'b0);

    // R11 start with a junk beat; the junk is not byte 0
    base_block();
    put_desc(3, 16'h3210, 12'h321, 12'h0FE, 12'h210, 12'h0DC, 10'h2BA, 10'h098, 6'h26, 6'h15, 8'h1C);
    fix_sum();
    expect_good(16'h3210, 12'h321, 12'h0FE, 12'h210, 12'h0DC, 10'h2BA, 10'h098, 6'h26, 6'h15, 8'h1C);
    @(negedge clk);
    start = 1'b1; in_valid = 1'b1; in_byte = 8'h77;
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0;
    stream(0, 127, 1'b0);
    finish_check("R11 junk beat dropped");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule